// File: doc/BRIEF.md
# Frequency Acquisition and Lock Detector

This block steers a digitally controlled oscillator onto the rate of an incoming data stream. Every measurement window is a fixed number of clock cycles. Over each window it counts oscillator events and data transition events. From the two counts it forms a frequency error in parts per million. The comparison uses integer products only; it never divides.

While it is out of lock, the block raises the control word from the bottom of its range. It begins with large steps, which get smaller as the remaining error shrinks. When the error is small enough, it declares lock, freezes the control word and enables an external phase-tracking loop. Measurement goes on while locked. A large error drops the block back into a fresh search from the bottom of the range.

The two thresholds differ, which gives hysteresis. Lock is declared at 250 ppm or better. Lock is lost only above 1000 ppm.

Top module: `fal_freq_acq`

## Requirements
- R1: On reset, `ctrl_word` equals CW_MIN (16), `lol` is 1 and `loop_en` is 0.
- R2: A measurement window lasts WIN_CYCLES (2048) clock cycles, and the first window starts at the first rising edge after reset is released. `ctrl_word` changes only at the edge that follows the close of a window, so counting edges after release from 1, a change happens only at edge k*WIN_CYCLES+1.
- R3: While searching, `ctrl_word` only increases. It increases only when the oscillator count is below the data count and the error is above the lock threshold.
- R4: The first increment after a search starts is MAX_STEP (512). A window whose error lies below the current step band halves the step instead of incrementing. Every increment is a power of two no larger than the increment before it, and the smallest step is 1.
- R5: With a reachable target, `lol` falls within 24 windows of the search start. From the moment lock is declared, `loop_en` is 1 and `lol` is 0, and the two flags are never equal.
- R6: While locked, `ctrl_word` does not change.
- R7: While locked, an error between 250 ppm and 1000 ppm keeps the block locked.
- R8: While locked, an error above 1000 ppm sets `lol`, clears `loop_en`, and returns `ctrl_word` to CW_MIN in the same cycle. A new search then follows.
- R9: The error is |osc - data| * 10^6 compared against threshold * data, where both are counts over one window. The lock point is therefore the first control word, going upward, within 250 ppm of the data rate.
- R10: If the oscillator is already faster than the data while searching, the control word holds and `lol` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_events | input | EV_W (4) | Oscillator events seen this clock cycle |
| data_events | input | EV_W (4) | Data transition events seen this clock cycle |
| ctrl_word | output | CW_W (12) | Oscillator control word |
| lol | output | 1 | Loss-of-lock flag, 1 while searching |
| loop_en | output | 1 | Enables the external phase loop, 1 while locked |

## Verification
A wrong step register shows up at the ports within one window. It appears as an increment that is not a power of two, an increment larger than the previous one, or an overshoot that lands the lock point on the wrong control word. A wrong window counter moves `ctrl_word` on an edge not aligned to WIN_CYCLES, and this is visible at the very first update. A wrong threshold or a swapped comparison either keeps `lol` high when the target is reached, or drops lock during the 600 ppm hold. Either fault becomes visible within two to three windows of the data-rate change.

// File: rtl/fal_pkg.sv
package fal_pkg;
   typedef enum logic {
      ACQ_SEARCH = 1'b0,
      ACQ_LOCKED = 1'b1
   } acq_state_e;

   localparam int PPM_SCALE = 1000000;
endpackage

// File: rtl/fal_window_counter.sv
module fal_window_counter #(
   parameter int WIN_CYCLES = 2048,
   parameter int EV_W       = 4,
   parameter int CNT_W      = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EV_W-1:0]  osc_inc,
   input  logic [EV_W-1:0]  ref_inc,
   output logic             meas_valid,
   output logic [CNT_W-1:0] osc_cnt,
   output logic [CNT_W-1:0] ref_cnt
);
   localparam int WIN_W = $clog2(WIN_CYCLES);

   logic [WIN_W-1:0] win_q;
   logic [CNT_W-1:0] osc_acc, ref_acc;
   logic             last;

   assign last = (win_q == WIN_W'(WIN_CYCLES - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win_q      <= '0;
         osc_acc    <= '0;
         ref_acc    <= '0;
         meas_valid <= 1'b0;
         osc_cnt    <= '0;
         ref_cnt    <= '0;
      end else begin
         meas_valid <= last;
         if (last) begin
            osc_cnt <= osc_acc + CNT_W'(osc_inc);
            ref_cnt <= ref_acc + CNT_W'(ref_inc);
            osc_acc <= '0;
            ref_acc <= '0;
            win_q   <= '0;
         end else begin
            osc_acc <= osc_acc + CNT_W'(osc_inc);
            ref_acc <= ref_acc + CNT_W'(ref_inc);
            win_q   <= win_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/fal_ppm_thresh.sv
module fal_ppm_thresh
   import fal_pkg::*;
#(
   parameter int CNT_W   = 15,
   parameter int THR_PPM = 1000
) (
   input  logic [CNT_W-1:0] diff,
   input  logic [CNT_W-1:0] ref_cnt,
   output logic             over
);
   localparam int SCALE_W = $clog2(PPM_SCALE) + 1;
   localparam int PROD_W  = CNT_W + SCALE_W;

   logic [PROD_W-1:0] lhs, rhs;

   assign lhs  = PROD_W'(diff) * PROD_W'(PPM_SCALE);
   assign rhs  = PROD_W'(ref_cnt) * PROD_W'(THR_PPM);
   assign over = (lhs > rhs);
endmodule

// File: rtl/fal_step_ctrl.sv
module fal_step_ctrl
   import fal_pkg::*;
#(
   parameter int CW_W     = 12,
   parameter int CNT_W    = 15,
   parameter int CW_MIN   = 16,
   parameter int MAX_STEP = 512
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             meas_valid,
   input  logic [CNT_W-1:0] osc_cnt,
   input  logic [CNT_W-1:0] diff,
   input  logic             osc_below,
   input  logic             over_lock,
   input  logic             over_lose,
   output logic [CW_W-1:0]  ctrl_word,
   output acq_state_e       state
);
   localparam int STEP_W = $clog2(MAX_STEP) + 1;
   localparam int BAND_W = CNT_W + CW_W + 1;

   logic [CW_W-1:0]   cw_q;
   logic [STEP_W-1:0] step_q;
   acq_state_e        state_q;
   logic [BAND_W-1:0] err_scaled, band_scaled;
   logic              below_band, step_is_min;
   logic [CW_W:0]     cw_sum;

   assign err_scaled  = BAND_W'(diff) * BAND_W'(cw_q);
   assign band_scaled = BAND_W'(step_q) * BAND_W'(osc_cnt);
   assign below_band  = (err_scaled < band_scaled);
   assign step_is_min = (step_q == STEP_W'(1));
   assign cw_sum      = {1'b0, cw_q} + (CW_W+1)'(step_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cw_q    <= CW_W'(CW_MIN);
         step_q  <= STEP_W'(MAX_STEP);
         state_q <= ACQ_SEARCH;
      end else if (meas_valid) begin
         unique case (state_q)
            ACQ_SEARCH: begin
               if (!over_lock) begin
                  state_q <= ACQ_LOCKED;
               end else if (osc_below) begin
                  if (!step_is_min && (below_band || cw_sum[CW_W])) begin
                     step_q <= step_q >> 1;
                  end else if (!cw_sum[CW_W]) begin
                     cw_q <= cw_sum[CW_W-1:0];
                  end
               end
            end
            ACQ_LOCKED: begin
               if (over_lose) begin
                  state_q <= ACQ_SEARCH;
                  cw_q    <= CW_W'(CW_MIN);
                  step_q  <= STEP_W'(MAX_STEP);
               end
            end
            default: state_q <= ACQ_SEARCH;
         endcase
      end
   end

   assign ctrl_word = cw_q;
   assign state     = state_q;
endmodule

// File: rtl/fal_freq_acq.sv
module fal_freq_acq
   import fal_pkg::*;
#(
   parameter int CW_W       = 12,
   parameter int CW_MIN     = 16,
   parameter int MAX_STEP   = 512,
   parameter int WIN_CYCLES = 2048,
   parameter int EV_W       = 4,
   parameter int LOCK_PPM   = 250,
   parameter int LOSE_PPM   = 1000
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [EV_W-1:0] osc_events,
   input  logic [EV_W-1:0] data_events,
   output logic [CW_W-1:0] ctrl_word,
   output logic            lol,
   output logic            loop_en
);
   localparam int CNT_W   = $clog2(WIN_CYCLES * (2**EV_W - 1) + 1);
   localparam int N_THR   = 2;
   localparam int IDX_LCK = 0;
   localparam int IDX_LOS = 1;

   if (MAX_STEP < 1 || (MAX_STEP & (MAX_STEP - 1)) != 0) begin : g_bad_step
      $error("MAX_STEP must be a power of two");
   end
   if (CW_MIN + MAX_STEP >= 2**CW_W) begin : g_bad_range
      $error("CW_MIN + MAX_STEP must fit in CW_W bits");
   end
   if (LOCK_PPM >= LOSE_PPM || LOSE_PPM >= PPM_SCALE) begin : g_bad_thr
      $error("thresholds must satisfy LOCK_PPM < LOSE_PPM < 1e6");
   end
   if (WIN_CYCLES < 2) begin : g_bad_win
      $error("WIN_CYCLES must be at least 2");
   end

   logic             meas_valid;
   logic [CNT_W-1:0] osc_cnt, ref_cnt, diff;
   logic             osc_below;
   logic [N_THR-1:0] over;
   acq_state_e       state;

   fal_window_counter #(
      .WIN_CYCLES(WIN_CYCLES),
      .EV_W      (EV_W),
      .CNT_W     (CNT_W)
   ) u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .osc_inc   (osc_events),
      .ref_inc   (data_events),
      .meas_valid(meas_valid),
      .osc_cnt   (osc_cnt),
      .ref_cnt   (ref_cnt)
   );

   assign osc_below = (osc_cnt < ref_cnt);
   assign diff      = osc_below ? (ref_cnt - osc_cnt) : (osc_cnt - ref_cnt);

   for (genvar g = 0; g < N_THR; g++) begin : g_thr
      fal_ppm_thresh #(
         .CNT_W  (CNT_W),
         .THR_PPM((g == IDX_LCK) ? LOCK_PPM : LOSE_PPM)
      ) u_thr (
         .diff   (diff),
         .ref_cnt(ref_cnt),
         .over   (over[g])
      );
   end

   fal_step_ctrl #(
      .CW_W    (CW_W),
      .CNT_W   (CNT_W),
      .CW_MIN  (CW_MIN),
      .MAX_STEP(MAX_STEP)
   ) u_step (
      .clk       (clk),
      .rst_n     (rst_n),
      .meas_valid(meas_valid),
      .osc_cnt   (osc_cnt),
      .diff      (diff),
      .osc_below (osc_below),
      .over_lock (over[IDX_LCK]),
      .over_lose (over[IDX_LOS]),
      .ctrl_word (ctrl_word),
      .state     (state)
   );

   assign lol     = (state == ACQ_SEARCH);
   assign loop_en = (state == ACQ_LOCKED);
endmodule

// File: rtl/fal_freq_acq_chk.sv
module fal_freq_acq_chk #(
   parameter int CW_W     = 12,
   parameter int CW_MIN   = 16,
   parameter int MAX_STEP = 512
) (
   input logic            clk,
   input logic            rst_n,
   input logic [CW_W-1:0] ctrl_word,
   input logic            lol,
   input logic            loop_en,
   input logic            meas_valid
);
   AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      lol != loop_en); // R5

   AST_UPD_AFTER_WIN: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_word != $past(ctrl_word)) |-> $past(meas_valid)); // R2

   AST_SEARCH_UP: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(lol) && lol && ctrl_word != $past(ctrl_word))
         |-> (ctrl_word > $past(ctrl_word))); // R3

   AST_POW2_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(lol) && lol && ctrl_word != $past(ctrl_word))
         |-> ($countones(ctrl_word - $past(ctrl_word)) == 1)); // R4

   AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(lol) && lol)
         |-> ((ctrl_word - $past(ctrl_word)) <= CW_W'(MAX_STEP))); // R4

   AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(lol) && !lol) |-> $stable(ctrl_word)); // R6

   AST_RESTART_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lol) |-> (ctrl_word == CW_W'(CW_MIN))); // R8
endmodule

bind fal_freq_acq fal_freq_acq_chk #(
   .CW_W    (CW_W),
   .CW_MIN  (CW_MIN),
   .MAX_STEP(MAX_STEP)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ctrl_word (ctrl_word),
   .lol       (lol),
   .loop_en   (loop_en),
   .meas_valid(meas_valid)
);

// File: tb/fal_freq_acq_tb.sv
`timescale 1ns/1ps
module fal_freq_acq_tb_top;
   localparam int CW_W     = 12;
   localparam int CW_MIN   = 16;
   localparam int MAX_STEP = 512;
   localparam int WIN      = 2048;
   localparam int EV_W     = 4;
   localparam int GAIN     = 64;     // oscillator model: ctrl_word*GAIN / 2^15 events per cycle
   localparam int ACC_MOD  = 32768;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [EV_W-1:0] osc_events = '0;
   logic [EV_W-1:0] data_events = '0;
   logic [CW_W-1:0] ctrl_word;
   logic            lol;
   logic            loop_en;

   int checks = 0;
   int failures = 0;
   int ecount = 0;
   int dfw = 128080;
   int oacc = 0;
   int dacc = 0;

   always #2 clk = ~clk;

   fal_freq_acq #(
      .CW_W      (CW_W),
      .CW_MIN    (CW_MIN),
      .MAX_STEP  (MAX_STEP),
      .WIN_CYCLES(WIN),
      .EV_W      (EV_W)
   ) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .osc_events (osc_events),
      .data_events(data_events),
      .ctrl_word  (ctrl_word),
      .lol        (lol),
      .loop_en    (loop_en)
   );

   always @(posedge clk) begin
      if (!rst_n) ecount <= 0;
      else        ecount <= ecount + 1;
   end

   // oscillator and data stream models, driven away from the active edge
   always @(negedge clk) begin
      if (!rst_n) begin
         oacc = 0;
         dacc = 0;
         osc_events <= '0;
         data_events <= '0;
      end else begin
         oacc = oacc + int'(ctrl_word) * GAIN;
         dacc = dacc + dfw;
         osc_events <= EV_W'(oacc / ACC_MOD);
         data_events <= EV_W'(dacc / ACC_MOD);
         oacc = oacc % ACC_MOD;
         dacc = dacc % ACC_MOD;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic bit within_ppm(input longint cw, input longint fw, input longint ppm);
      longint d;
      d = cw * GAIN - fw;
      if (d < 0) d = -d;
      return (d * 1000000) <= (ppm * fw);
   endfunction

   task automatic do_reset(input int fw);
      @(negedge clk);
      rst_n = 1'b0;
      dfw = fw;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset_state();
      do_reset(128080);
      chk(ctrl_word == CW_W'(CW_MIN), "R1", "ctrl_word after reset", ctrl_word, CW_MIN);
      chk(lol == 1'b1, "R1", "lol after reset", lol, 1);
      chk(loop_en == 1'b0, "R1", "loop_en after reset", loop_en, 0);
   endtask

   // R2 R3 R4 R5 R9: search from the floor to lock
   task automatic t_acquire(input int fw, input bit from_reset, input string tag);
      int  prev_cw    = int'(ctrl_word);
      int  prev_delta = MAX_STEP;
      int  start_e    = ecount;
      bit  first      = 1'b1;
      bit  locked     = 1'b0;
      dfw = fw;
      while (!locked && (ecount - start_e) < 24 * WIN) begin
         @(negedge clk);
         if (int'(ctrl_word) != prev_cw) begin
            int delta = int'(ctrl_word) - prev_cw;
            chk(((ecount - 1) % WIN) == 0, "R2", {tag, " update edge phase"}, (ecount - 1) % WIN, 0);
            chk(delta > 0, "R3", {tag, " search moves up"}, delta, 1);
            chk(delta > 0 && (delta & (delta - 1)) == 0, "R4", {tag, " step power of two"}, delta, 0);
            chk(delta <= prev_delta, "R4", {tag, " step non-increasing"}, delta, prev_delta);
            if (first) begin
               chk(delta == MAX_STEP, "R4", {tag, " first step"}, delta, MAX_STEP);
               if (from_reset)
                  chk(ecount == WIN + 1, "R2", {tag, " first update edge"}, ecount, WIN + 1);
               first = 1'b0;
            end
            prev_delta = delta;
            prev_cw = int'(ctrl_word);
         end
         if (!lol) locked = 1'b1;
      end
      chk(locked, "R5", {tag, " lock within 24 windows"}, (ecount - start_e) / WIN, 24);
      chk(loop_en == 1'b1, "R5", {tag, " loop_en at lock"}, loop_en, 1);
      chk(within_ppm(longint'(ctrl_word), fw, 250), "R9", {tag, " lock word within 250 ppm"},
          ctrl_word, fw / GAIN);
      chk(!within_ppm(longint'(ctrl_word) - 1, fw, 250), "R9", {tag, " lock at first word in band"},
          ctrl_word, fw / GAIN);
   endtask

   // R6 R7: 600 ppm offset while locked
   task automatic t_hold_band();
      int held = int'(ctrl_word);
      int dropped = 0;
      dfw = (held * GAIN * 10006) / 10000;
      repeat (4 * WIN) begin
         @(negedge clk);
         if (lol) dropped++;
      end
      chk(dropped == 0, "R7", "lock kept at 600 ppm", dropped, 0);
      chk(int'(ctrl_word) == held, "R6", "ctrl_word frozen while locked", ctrl_word, held);
      chk(loop_en == 1'b1, "R7", "loop_en kept at 600 ppm", loop_en, 1);
   endtask

   // R8: 1500 ppm offset while locked
   task automatic t_lose(output int new_fw);
      int  held = int'(ctrl_word);
      bit  seen = 1'b0;
      int  cw_at = 0;
      int  en_at = 1;
      new_fw = (held * GAIN * 10015) / 10000;
      dfw = new_fw;
      for (int i = 0; i < 3 * WIN && !seen; i++) begin
         @(negedge clk);
         if (lol) begin
            seen = 1'b1;
            cw_at = int'(ctrl_word);
            en_at = int'(loop_en);
         end
      end
      chk(seen, "R8", "lock lost at 1500 ppm", seen, 1);
      chk(cw_at == CW_MIN, "R8", "ctrl_word back to floor", cw_at, CW_MIN);
      chk(en_at == 0, "R8", "loop_en cleared", en_at, 0);
   endtask

   // R10: oscillator already faster than data
   task automatic t_fast_osc();
      do_reset(500);
      repeat (4 * WIN + 2) @(negedge clk);
      chk(ctrl_word == CW_W'(CW_MIN), "R10", "ctrl_word holds when osc fast", ctrl_word, CW_MIN);
      chk(lol == 1'b1, "R10", "lol stays set when osc fast", lol, 1);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", ecount, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      int fw2;
      t_reset_state();
      t_acquire(128080, 1'b1, "first");
      t_hold_band();
      t_lose(fw2);
      t_acquire(fw2, 1'b0, "relock");
      t_fast_osc();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule